// File: doc/BRIEF.md
# Memory Card SPI Start-Up Sequencer

This block takes a removable flash memory card from power-up to the ready state over SPI. It does not shift bits itself. It drives a byte-wide SPI master: it asks for one byte exchange at a time and reads the byte that comes back. It also controls chip select and a slow/fast clock select.

After a start pulse, the sequencer works through these steps in order:
- clock out a wake-up train of idle bytes with the card deselected;
- issue the reset command;
- issue the interface-condition check, whose echo marks a version-2 card;
- repeat the application-command prefix and the operating-condition command until the card leaves the idle state.

Every command frame carries a CRC7 computed by the block. Cards that check CRC from power-up therefore accept the prefix and the operating-condition command, not only the first two commands. Some idle bytes separate the prefix response from the following frame. When the sequence ends, the block reports done, the card version, or a numeric error code.

Top module: `sdspi_init_seq`

## Requirements
- R1: After start, and before any command, the block clocks out at least WAKE_BYTES (default 10, that is 80 clocks) bytes of 0xFF. During these bytes cs_n is high and slow_clk is high.
- R2: Each command frame is six bytes, in this order:
  - byte 0 is 0b01 followed by the 6-bit command index;
  - bytes 1 to 4 are the 32-bit argument, most significant byte first;
  - byte 5 holds the CRC7 (x^7+x^3+1 over bytes 0 to 4) in bits 7:1 and a 1 in bit 0.
  
  The reset command (index 0, argument 0) therefore ends in 0x95. The check command (index 8, argument 0x000001AA) ends in 0x87. Indices 55 and 41 also carry a valid CRC7.
- R3: After a frame, the block sends up to RESP_POLLS (default 8) bytes of 0xFF with cs_n low. The first returned byte with bit 7 clear is the response. If no such byte arrives, the block stops with err_code 1.
- R4: The reset command must be answered with 0x01. Any other response, except 0x05 and 0x09, stops the block with err_code 4.
- R5: The check command is answered with 0x01 followed by four bytes.
  - If the four bytes equal 0x000001AA, card_v2 is set and the sequence continues.
  - If they differ, the block stops with err_code 5.
- R6: After the response to index 55, the block sends GAP_BYTES (default 2) bytes of 0xFF with cs_n still low, then starts the index-41 frame. The index-41 argument is 0x40000000 when card_v2 is set.
- R7: Index 41 answered with 0x01 repeats the index 55/41 pair. An answer of 0x00 completes the sequence with done high. If MAX_TRIES index-41 attempts are all answered with 0x01, the block stops with err_code 6.
- R8: A response of 0x05 to any command stops the block with err_code 2. A response of 0x09 stops it with err_code 3. While done is high, err_code is 0. An error code holds until the next start.
- R9: After each command other than index 55, cs_n goes high and one extra 0xFF byte is clocked out before the next step.
- R10: After reset, the block is idle:
  - busy, done, card_v2 and err_code are all 0;
  - cs_n and slow_clk are high;
  - no transfer is requested.
  
  On completion, slow_clk goes low, busy goes low, done goes high and no more transfers are requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse to begin (accepted when not busy) |
| xfer_start | output | 1 | One-cycle request for a byte exchange |
| xfer_tx | output | 8 | Byte to transmit, valid with xfer_start |
| xfer_done | input | 1 | One-cycle pulse: exchange finished |
| xfer_rx | input | 8 | Byte received, valid with xfer_done |
| cs_n | output | 1 | Card chip select, active low |
| slow_clk | output | 1 | High selects the sub-400 kHz SPI clock |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Card ready |
| card_v2 | output | 1 | Interface-condition echo matched |
| err_code | output | 3 | 0 none, 1 no response, 2 illegal, 3 CRC, 4 unexpected, 5 echo mismatch, 6 retries exhausted |

## Verification
The bench models a card that rejects every frame whose CRC7 or stop bit is wrong. A design that used a dummy CRC on indices 55 and 41 would therefore show a non-zero CRC-error count.

A card that answers on the last allowed poll separates an off-by-one poll limit from a correct one. A silent card shows whether the block polls exactly RESP_POLLS bytes.

A card that stays idle forever shows whether the retry limit counts attempts exactly. Responses of 0x05 and 0x09 to the prefix, a wrong echo, and a wrong reset answer each check that the right distinct error code is latched. Counts of gap bytes, trailer bytes and wake-up bytes would expose a frame that started too early or a chip-select release that was missing.

// File: rtl/sdspi_init_pkg.sv
package sdspi_init_pkg;

   typedef enum logic [1:0] {
      C_RST = 2'd0,
      C_IFC = 2'd1,
      C_APP = 2'd2,
      C_OPC = 2'd3
   } cmd_e;

   typedef enum logic [2:0] {
      ERR_NONE    = 3'd0,
      ERR_NORESP  = 3'd1,
      ERR_ILLEGAL = 3'd2,
      ERR_CRC     = 3'd3,
      ERR_UNEXP   = 3'd4,
      ERR_ECHO    = 3'd5,
      ERR_INIT_TO = 3'd6
   } err_e;

   typedef enum logic [2:0] {
      V_TRAIL,
      V_ECHO,
      V_GAP,
      V_RETRY,
      V_FINISH,
      V_FAIL
   } verdict_e;

   localparam logic [7:0]  R1_IDLE    = 8'h01;
   localparam logic [7:0]  R1_READY   = 8'h00;
   localparam logic [7:0]  R1_ILLEGAL = 8'h05;
   localparam logic [7:0]  R1_CRCERR  = 8'h09;
   localparam logic [31:0] IFC_ARG    = 32'h0000_01AA;
   localparam logic [31:0] HCS_ARG    = 32'h4000_0000;

endpackage

// File: rtl/sdspi_crc7.sv
module sdspi_crc7 #(
   parameter int W = 40
) (
   input  logic [W-1:0] data,
   output logic [6:0]   crc
);
   logic [6:0] stage [0:W];

   assign stage[0] = 7'd0;

   for (genvar g = 0; g < W; g++) begin : g_bit
      logic fb;
      assign fb           = stage[g][6] ^ data[W-1-g];
      assign stage[g+1]   = {stage[g][5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
   end

   assign crc = stage[W];
endmodule

// File: rtl/sdspi_frame_gen.sv
module sdspi_frame_gen
   import sdspi_init_pkg::*;
#(
   parameter bit HCS_REQUEST = 1'b1
) (
   input  cmd_e       cmd,
   input  logic       v2,
   input  logic [2:0] idx,
   output logic [7:0] byte_out
);
   localparam int HDR_W   = 40;
   localparam int FRAME_W = 48;

   logic [5:0]         index;
   logic [31:0]        arg;
   logic [31:0]        opc_arg;
   logic [HDR_W-1:0]   hdr;
   logic [6:0]         crc;
   logic [FRAME_W-1:0] frame;

   if (HCS_REQUEST) begin : g_hcs
      assign opc_arg = v2 ? HCS_ARG : 32'd0;
   end else begin : g_nohcs
      assign opc_arg = 32'd0;
   end

   always_comb begin
      unique case (cmd)
         C_RST:   begin index = 6'd0;  arg = 32'd0;   end
         C_IFC:   begin index = 6'd8;  arg = IFC_ARG; end
         C_APP:   begin index = 6'd55; arg = 32'd0;   end
         default: begin index = 6'd41; arg = opc_arg; end
      endcase
   end

   assign hdr = {2'b01, index, arg};

   sdspi_crc7 #(.W(HDR_W)) u_crc (
      .data(hdr),
      .crc (crc)
   );

   assign frame = {hdr, crc, 1'b1};

   always_comb begin
      byte_out = 8'hFF;
      for (int i = 0; i < 6; i++) begin
         if (idx == 3'(i)) byte_out = frame[FRAME_W-1-8*i -: 8];
      end
   end
endmodule

// File: rtl/sdspi_r1_judge.sv
module sdspi_r1_judge
   import sdspi_init_pkg::*;
(
   input  cmd_e       cmd,
   input  logic [7:0] r1,
   input  logic       last_try,
   output verdict_e   vd,
   output err_e       ec,
   output cmd_e       nxt
)
;
   always_comb begin
      vd  = V_FAIL;
      ec  = ERR_UNEXP;
      nxt = C_APP;
      if (r1 == R1_ILLEGAL) begin
         ec = ERR_ILLEGAL;
      end else if (r1 == R1_CRCERR) begin
         ec = ERR_CRC;
      end else begin
         unique case (cmd)
            C_RST: if (r1 == R1_IDLE) begin vd = V_TRAIL; nxt = C_IFC; end
            C_IFC: if (r1 == R1_IDLE) vd = V_ECHO;
            C_APP: if (r1 == R1_IDLE || r1 == R1_READY) vd = V_GAP;
            default: begin
               if (r1 == R1_READY) vd = V_FINISH;
               else if (r1 == R1_IDLE) begin
                  if (last_try) ec = ERR_INIT_TO;
                  else          vd = V_RETRY;
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/sdspi_init_seq.sv
module sdspi_init_seq
   import sdspi_init_pkg::*;
#(
   parameter int WAKE_BYTES  = 10,
   parameter int RESP_POLLS  = 8,
   parameter int GAP_BYTES   = 2,
   parameter int MAX_TRIES   = 1000,
   parameter bit HCS_REQUEST = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   output logic       xfer_start,
   output logic [7:0] xfer_tx,
   input  logic       xfer_done,
   input  logic [7:0] xfer_rx,
   output logic       cs_n,
   output logic       slow_clk,
   output logic       busy,
   output logic       done,
   output logic       card_v2,
   output logic [2:0] err_code
);
   localparam int M1   = (WAKE_BYTES > RESP_POLLS) ? WAKE_BYTES : RESP_POLLS;
   localparam int M2   = (GAP_BYTES > 6) ? GAP_BYTES : 6;
   localparam int MAXC = (M1 > M2) ? M1 : M2;
   localparam int CW   = $clog2(MAXC + 1);
   localparam int TW   = $clog2(MAX_TRIES + 1);

   if (WAKE_BYTES < 10) begin : g_chk_wake
      $error("WAKE_BYTES must give at least 80 clocks");
   end
   if (RESP_POLLS < 1 || GAP_BYTES < 1 || MAX_TRIES < 1) begin : g_chk_cnt
      $error("RESP_POLLS, GAP_BYTES and MAX_TRIES must be at least 1");
   end

   typedef enum logic [3:0] {
      ST_IDLE, ST_WAKE, ST_FRAME, ST_POLL, ST_ECHO,
      ST_GAP, ST_TRAIL, ST_DONE, ST_FAIL
   } state_e;

   state_e         state;
   cmd_e           cmd, cmd_nx;
   logic [CW-1:0]  cnt;
   logic [TW-1:0]  tries;
   logic [23:0]    echo_q;
   logic           wait_q, fin, v2_q, start_q;
   logic [7:0]     tx_q;
   err_e           err_q;
   logic [7:0]     frame_byte, tx_w;
   logic           xfer_state;
   verdict_e       vd;
   err_e           vd_err;
   cmd_e           vd_nxt;

   sdspi_frame_gen #(.HCS_REQUEST(HCS_REQUEST)) u_frame (
      .cmd     (cmd),
      .v2      (v2_q),
      .idx     (cnt[2:0]),
      .byte_out(frame_byte)
   );

   sdspi_r1_judge u_judge (
      .cmd     (cmd),
      .r1      (xfer_rx),
      .last_try(tries == TW'(MAX_TRIES - 1)),
      .vd      (vd),
      .ec      (vd_err),
      .nxt     (vd_nxt)
   );

   assign xfer_state = state inside {ST_WAKE, ST_FRAME, ST_POLL, ST_ECHO, ST_GAP, ST_TRAIL};
   assign tx_w       = (state == ST_FRAME) ? frame_byte : 8'hFF;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cmd     <= C_RST;
         cmd_nx  <= C_RST;
         cnt     <= '0;
         tries   <= '0;
         echo_q  <= '0;
         wait_q  <= 1'b0;
         fin     <= 1'b0;
         v2_q    <= 1'b0;
         start_q <= 1'b0;
         tx_q    <= 8'hFF;
         err_q   <= ERR_NONE;
      end else begin
         start_q <= 1'b0;
         if (start && !xfer_state) begin
            state  <= ST_WAKE;
            cmd    <= C_RST;
            cnt    <= '0;
            tries  <= '0;
            v2_q   <= 1'b0;
            fin    <= 1'b0;
            wait_q <= 1'b0;
            err_q  <= ERR_NONE;
         end else if (xfer_state && !wait_q) begin
            start_q <= 1'b1;
            tx_q    <= tx_w;
            wait_q  <= 1'b1;
         end else if (wait_q && xfer_done) begin
            wait_q <= 1'b0;
            unique case (state)
               ST_WAKE: begin
                  if (cnt == CW'(WAKE_BYTES - 1)) begin
                     state <= ST_FRAME;
                     cnt   <= '0;
                  end else cnt <= cnt + 1'b1;
               end
               ST_FRAME: begin
                  if (cnt == CW'(5)) begin
                     state <= ST_POLL;
                     cnt   <= '0;
                  end else cnt <= cnt + 1'b1;
               end
               ST_POLL: begin
                  if (!xfer_rx[7]) begin
                     cnt <= '0;
                     unique case (vd)
                        V_ECHO: state <= ST_ECHO;
                        V_GAP:  state <= ST_GAP;
                        V_TRAIL: begin
                           state  <= ST_TRAIL;
                           cmd_nx <= vd_nxt;
                        end
                        V_RETRY: begin
                           state  <= ST_TRAIL;
                           cmd_nx <= C_APP;
                           tries  <= tries + 1'b1;
                        end
                        V_FINISH: begin
                           state <= ST_TRAIL;
                           fin   <= 1'b1;
                        end
                        default: begin
                           state <= ST_FAIL;
                           err_q <= vd_err;
                        end
                     endcase
                  end else if (cnt == CW'(RESP_POLLS - 1)) begin
                     state <= ST_FAIL;
                     err_q <= ERR_NORESP;
                  end else cnt <= cnt + 1'b1;
               end
               ST_ECHO: begin
                  echo_q <= {echo_q[15:0], xfer_rx};
                  if (cnt == CW'(3)) begin
                     cnt <= '0;
                     if ({echo_q, xfer_rx} == IFC_ARG) begin
                        v2_q   <= 1'b1;
                        cmd_nx <= C_APP;
                        state  <= ST_TRAIL;
                     end else begin
                        state <= ST_FAIL;
                        err_q <= ERR_ECHO;
                     end
                  end else cnt <= cnt + 1'b1;
               end
               ST_GAP: begin
                  if (cnt == CW'(GAP_BYTES - 1)) begin
                     state <= ST_FRAME;
                     cmd   <= C_OPC;
                     cnt   <= '0;
                  end else cnt <= cnt + 1'b1;
               end
               ST_TRAIL: begin
                  cnt <= '0;
                  if (fin) state <= ST_DONE;
                  else begin
                     state <= ST_FRAME;
                     cmd   <= cmd_nx;
                  end
               end
               default: state <= state;
            endcase
         end
      end
   end

   assign xfer_start = start_q;
   assign xfer_tx    = tx_q;
   assign cs_n       = !(state inside {ST_FRAME, ST_POLL, ST_ECHO, ST_GAP});
   assign slow_clk   = (state != ST_DONE);
   assign busy       = xfer_state;
   assign done       = (state == ST_DONE);
   assign card_v2    = v2_q;
   assign err_code   = err_q;
endmodule

// File: rtl/sdspi_init_chk.sv
module sdspi_init_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       start,
   input logic       xfer_start,
   input logic [7:0] xfer_tx,
   input logic       cs_n,
   input logic       busy,
   input logic       done,
   input logic [2:0] err_code
);
   p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start |=> !xfer_start);

   p_deselect_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_start && cs_n) |-> (xfer_tx == 8'hFF));

   p_done_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (err_code == 3'd0));

   p_err_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (err_code != 3'd0 && !start) |=> $stable(err_code));

   p_quiet_after_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> !xfer_start);

   p_req_in_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start |-> (busy && !done));
endmodule

bind sdspi_init_seq sdspi_init_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .xfer_start(xfer_start),
   .xfer_tx   (xfer_tx),
   .cs_n      (cs_n),
   .busy      (busy),
   .done      (done),
   .err_code  (err_code)
);

// File: tb/sdspi_init_seq_test.sv
module sdspi_init_seq_test;
   localparam int WAKE  = 10;
   localparam int POLLS = 8;
   localparam int GAP   = 2;
   localparam int TRIES = 5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic       xfer_start;
   logic [7:0] xfer_tx;
   logic       xfer_done = 1'b0;
   logic [7:0] xfer_rx = 8'hFF;
   logic       cs_n, slow_clk, busy, done, card_v2;
   logic [2:0] err_code;

   int checks = 0;
   int errors = 0;
   int cyc    = 0;

   sdspi_init_seq #(
      .WAKE_BYTES(WAKE), .RESP_POLLS(POLLS), .GAP_BYTES(GAP),
      .MAX_TRIES(TRIES), .HCS_REQUEST(1'b1)
   ) uut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .xfer_start(xfer_start), .xfer_tx(xfer_tx),
      .xfer_done(xfer_done), .xfer_rx(xfer_rx),
      .cs_n(cs_n), .slow_clk(slow_clk), .busy(busy), .done(done),
      .card_v2(card_v2), .err_code(err_code)
   );

   always #2 clk = ~clk;

   // ---------------- card model configuration and statistics ----------------
   logic [7:0]  r0_resp, r8_resp, r55_resp;
   logic [31:0] r8_echo;
   int          busy_n, resp_delay;
   bit          mute;

   logic [7:0]  fbuf [0:5];
   int          fcnt;
   logic [7:0]  q [0:15];
   int          qlen, qpos;
   bit          seen_frame;
   int          wake_cnt, slow_bad, crc_bad, cmd41_seen, idle_lo, last_gap;
   int          trail_cnt, frames;
   logic [31:0] arg41;
   logic [7:0]  crc0_byte, crc8_byte;

   function automatic logic [6:0] ref_crc7(input logic [39:0] d);
      logic [6:0] c = 7'd0;
      for (int i = 39; i >= 0; i--) begin
         logic f = c[6] ^ d[i];
         c = {c[5:0], 1'b0};
         if (f) c = c ^ 7'b0001001;
      end
      return c;
   endfunction

   task automatic card_reset();
      fcnt = 0; qlen = 0; qpos = 0; seen_frame = 0;
      wake_cnt = 0; slow_bad = 0; crc_bad = 0; cmd41_seen = 0;
      idle_lo = 0; last_gap = -1; trail_cnt = 0; frames = 0; arg41 = 32'hDEAD_BEEF;
      r0_resp = 8'h01; r8_resp = 8'h01; r55_resp = 8'h01; r8_echo = 32'h0000_01AA;
      busy_n = 0; resp_delay = 0; mute = 0;
   endtask

   task automatic push(input logic [7:0] b);
      q[qlen] = b;
      qlen++;
   endtask

   task automatic frame_end();
      logic [39:0] h;
      logic [5:0]  ix;
      logic [7:0]  r;
      h  = {fbuf[0], fbuf[1], fbuf[2], fbuf[3], fbuf[4]};
      ix = fbuf[0][5:0];
      frames++;
      if (fbuf[5] != {ref_crc7(h), 1'b1}) crc_bad++;
      if (ix == 6'd0) crc0_byte = fbuf[5];
      if (ix == 6'd8) crc8_byte = fbuf[5];
      if (ix == 6'd41) begin
         last_gap = idle_lo;
         arg41 = h[31:0];
         cmd41_seen++;
      end
      idle_lo = 0;
      qlen = 0; qpos = 0;
      if (mute) return;
      for (int i = 0; i < resp_delay; i++) push(8'hFF);
      case (ix)
         6'd0:    r = r0_resp;
         6'd8:    r = r8_resp;
         6'd55:   r = r55_resp;
         6'd41:   r = (cmd41_seen <= busy_n) ? 8'h01 : 8'h00;
         default: r = 8'h05;
      endcase
      push(r);
      if (ix == 6'd8 && r == 8'h01) begin
         push(r8_echo[31:24]); push(r8_echo[23:16]);
         push(r8_echo[15:8]);  push(r8_echo[7:0]);
      end
   endtask

   task automatic card_step(input logic [7:0] b, input logic sel_n, output logic [7:0] r);
      r = 8'hFF;
      if (sel_n) begin
         if (!seen_frame) begin
            if (b == 8'hFF) wake_cnt++;
            if (!slow_clk) slow_bad++;
         end else trail_cnt++;
         fcnt = 0;
      end else if (fcnt > 0 || (qpos >= qlen && b[7:6] == 2'b01)) begin
         fbuf[fcnt] = b;
         fcnt++;
         seen_frame = 1;
         if (fcnt == 6) begin
            fcnt = 0;
            frame_end();
         end
      end else if (qpos < qlen) begin
         r = q[qpos];
         qpos++;
      end else begin
         idle_lo++;
      end
   endtask

   // byte-exchange model: answers two negative edges after a request
   bit bm_busy = 0;
   int bm_lat = 0;
   logic [7:0] bm_reply;
   always @(negedge clk) begin
      if (bm_busy) begin
         if (bm_lat == 0) begin
            xfer_done = 1'b1;
            xfer_rx   = bm_reply;
            bm_busy   = 0;
         end else bm_lat--;
      end else begin
         xfer_done = 1'b0;
         if (xfer_start && rst_n) begin
            card_step(xfer_tx, cs_n, bm_reply);
            bm_busy = 1;
            bm_lat  = 1;
         end
      end
   end

   // ---------------- checking helpers ----------------
   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic run_seq();
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   // ---------------- scenarios ----------------
   task automatic t_reset();
      check(!busy && !done && !card_v2, "R10 idle flags", {busy, done, card_v2}, 0);
      check(err_code == 3'd0, "R10 reset err", err_code, 0);
      check(cs_n && slow_clk && !xfer_start, "R10 reset pins", {cs_n, slow_clk, xfer_start}, 3'b110);
   endtask

   task automatic t_normal();
      card_reset();
      busy_n = 2;
      run_seq();
      check(done && err_code == 0, "R7 completes", {done, err_code}, 4'h8);
      check(card_v2, "R5 v2 flag", card_v2, 1);
      check(wake_cnt == WAKE && slow_bad == 0, "R1 wake train", wake_cnt, WAKE);
      check(crc_bad == 0, "R2 CRC7 on all frames", crc_bad, 0);
      check(crc0_byte == 8'h95 && crc8_byte == 8'h87, "R2 fixed CRC bytes",
            {crc0_byte, crc8_byte}, 16'h9587);
      check(cmd41_seen == 3, "R7 retry count", cmd41_seen, 3);
      check(last_gap == GAP, "R6 gap bytes", last_gap, GAP);
      check(arg41 == 32'h4000_0000, "R6 HCS argument", arg41, 32'h4000_0000);
      check(trail_cnt == 5, "R9 trailer bytes", trail_cnt, 5);
      check(!slow_clk && !busy, "R10 fast after done", {slow_clk, busy}, 0);
      check(frames == 8, "R2 frame count", frames, 8);
   endtask

   task automatic t_late_reply();
      card_reset();
      resp_delay = POLLS - 1;
      run_seq();
      check(done && err_code == 0, "R3 reply on last poll", err_code, 0);
   endtask

   task automatic t_mute();
      card_reset();
      mute = 1;
      run_seq();
      check(err_code == 3'd1 && !done, "R3 no response", err_code, 1);
      check(idle_lo == POLLS, "R3 poll count", idle_lo, POLLS);
   endtask

   task automatic t_illegal();
      card_reset();
      r55_resp = 8'h05;
      run_seq();
      check(err_code == 3'd2, "R8 illegal command", err_code, 2);
      check(cmd41_seen == 0, "R8 abort before 41", cmd41_seen, 0);
   endtask

   task automatic t_crcerr();
      card_reset();
      r55_resp = 8'h09;
      run_seq();
      check(err_code == 3'd3, "R8 CRC error code", err_code, 3);
      repeat (10) @(negedge clk);
      check(err_code == 3'd3 && !busy, "R8 error holds", err_code, 3);
   endtask

   task automatic t_bad_reset();
      card_reset();
      r0_resp = 8'h00;
      run_seq();
      check(err_code == 3'd4, "R4 unexpected reset reply", err_code, 4);
   endtask

   task automatic t_echo();
      card_reset();
      r8_echo = 32'h0000_01AB;
      run_seq();
      check(err_code == 3'd5 && !card_v2, "R5 echo mismatch", err_code, 5);
   endtask

   task automatic t_timeout();
      card_reset();
      busy_n = 1000;
      run_seq();
      check(err_code == 3'd6 && !done, "R7 retries exhausted", err_code, 6);
      check(cmd41_seen == TRIES, "R7 attempt limit", cmd41_seen, TRIES);
   endtask

   initial begin
      card_reset();
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_normal();
      t_late_reply();
      t_mute();
      t_illegal();
      t_crcerr();
      t_bad_reset();
      t_echo();
      t_timeout();
      t_normal();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule